// File: doc/BRIEF.md
# SPI Baud Clock Generator

This block derives the serial clock of an SPI master from the module clock. The rate comes from a six-bit baud setting with two fields. A linear prescale field counts 0 to P. A power-of-two field selects a binary stage of 2^S. The serial clock period is (P+1)·2^(S+1) module-clock cycles, so its half-period is H = (P+1)·2^S. With the whole setting at zero, the module clock is divided by two.

Besides the clock waveform at the selected idle polarity, the block gives the shift logic two one-cycle strobes. One strobe tells the data path to launch the next bit. The other tells it to capture the incoming bit. The edge that each strobe uses follows the clock phase setting. A run input starts and stops the clock. A clock-enable input models an upstream clock gate: while it is low, the generator holds completely still.

Top module: `spi_bclk_gen`

## Requirements
- R1: While reset is asserted and right after it, `sclk_o`, `drive_o` and `sample_o` are all low. The reset configuration is a divide-by-two rate, idle level low and phase 0.
- R2: While the generator is idle, `sclk_o` equals the `cpol_i` value captured at the previous enabled clock edge.
- R3: `baud_i[5:3]` is the prescale field P and `baud_i[2:0]` is the power field S. While running, `sclk_o` changes level every H = (P+1)·2^S enabled cycles, which gives a 50% duty cycle.
- R4: If `run_i` is sampled high at enabled edge e0 while idle, the first `sclk_o` change appears at edge e0+H. Further changes follow every H enabled edges.
- R5: When `run_i` is sampled low while `sclk_o` is at its active level, the current half-period completes, `sclk_o` returns to the idle level, and no further edges follow. When `run_i` is sampled low at the idle level, the generator stops at once.
- R6: The leading edge is idle to active and the trailing edge is active to idle. With `cpha_i`=0, `sample_o` marks leading edges and `drive_o` marks trailing edges. With `cpha_i`=1 the two are swapped. Each strobe is high in exactly one enabled cycle: the one in which the new `sclk_o` level first appears.
- R7: `baud_i`, `cpol_i` and `cpha_i` are captured only at enabled edges where the generator is idle. A change made during a transfer has no effect on timing or polarity until the generator is idle again.
- R8: While `clk_en_i` is low, no counter or level changes, `sclk_o` holds, and both strobes are low. A strobe that is pending when the enable drops is shown in the next enabled cycle, once only.
- R9: `drive_o` and `sample_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock-enable; low freezes the whole generator |
| run_i | input | 1 | High requests serial clock activity |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Phase: selects which edge samples and which drives |
| baud_i | input | 6 | {prescale P[2:0], power S[2:0]} |
| sclk_o | output | 1 | Serial clock |
| drive_o | output | 1 | One-cycle strobe: launch the next bit |
| sample_o | output | 1 | One-cycle strobe: capture the incoming bit |

## Verification
Two functions of this block can fall in the same cycle. A stop request can arrive in the cycle where a half-period ends, and the clock-enable can drop in the cycle where an edge and its strobe are due. The random phase produces both. Run lengths are not tied to the half-period, and the enable is dropped on random cycles. A bench model with a single flat counter predicts `sclk_o` and both strobes in every cycle. The model judges whether a stop waits for the active half to finish, and whether a strobe that meets a low enable is shown exactly once after the enable returns.

// File: rtl/spi_bclk_pkg.sv
package spi_bclk_pkg;

   typedef enum logic [0:0] {
      LVL_IDLE   = 1'b0,
      LVL_ACTIVE = 1'b1
   } sclk_lvl_e;

   // capture strobe goes with the leading edge for phase 0, trailing for phase 1
   function automatic logic capture_on_edge(input logic leading, input logic cpha);
      return leading ^ cpha;
   endfunction

endpackage

// File: rtl/spi_bclk_prescale.sv
module spi_bclk_prescale #(
   parameter int PRE_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ce_i,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [PRE_W-1:0] limit_i,
   output logic             term_o
);

   logic [PRE_W-1:0] cnt_q;

   assign term_o = (cnt_q == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (ce_i) begin
         if (clr_i) begin
            cnt_q <= '0;
         end else if (inc_i) begin
            cnt_q <= term_o ? '0 : cnt_q + PRE_W'(1);
         end
      end
   end

endmodule

// File: rtl/spi_bclk_pow2.sv
module spi_bclk_pow2 #(
   parameter int SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ce_i,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             term_o
);

   localparam int STG_W = (1 << SEL_W) - 1;

   logic [STG_W-1:0] cnt_q;
   logic [STG_W-1:0] mask;

   // low S bits set: terminal value of a 2^S stage
   for (genvar i = 0; i < STG_W; i++) begin : g_mask
      assign mask[i] = (32'(sel_i) > i);
   end

   assign term_o = (cnt_q == mask);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (ce_i) begin
         if (clr_i) begin
            cnt_q <= '0;
         end else if (inc_i) begin
            cnt_q <= term_o ? '0 : cnt_q + STG_W'(1);
         end
      end
   end

endmodule

// File: rtl/spi_bclk_phase.sv
module spi_bclk_phase
   import spi_bclk_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ce_i,
   input  logic tick_i,
   input  logic cpol_i,
   input  logic cpha_i,
   output logic active_o,
   output logic sclk_o,
   output logic drive_o,
   output logic sample_o
);

   sclk_lvl_e lvl_q;
   logic      drv_q;
   logic      smp_q;
   logic      leading;
   logic      cap;

   assign leading  = (lvl_q == LVL_IDLE);
   assign cap      = capture_on_edge(leading, cpha_i);
   assign active_o = (lvl_q == LVL_ACTIVE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q <= LVL_IDLE;
         drv_q <= 1'b0;
         smp_q <= 1'b0;
      end else if (ce_i) begin
         drv_q <= tick_i & ~cap;
         smp_q <= tick_i & cap;
         if (tick_i) begin
            lvl_q <= leading ? LVL_ACTIVE : LVL_IDLE;
         end
      end
   end

   assign sclk_o   = active_o ^ cpol_i;
   // a held strobe is only shown in an enabled cycle
   assign drive_o  = drv_q & ce_i;
   assign sample_o = smp_q & ce_i;

endmodule

// File: rtl/spi_bclk_gen.sv
module spi_bclk_gen #(
   parameter int PRE_W = 3,
   parameter int SEL_W = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   clk_en_i,
   input  logic                   run_i,
   input  logic                   cpol_i,
   input  logic                   cpha_i,
   input  logic [PRE_W+SEL_W-1:0] baud_i,
   output logic                   sclk_o,
   output logic                   drive_o,
   output logic                   sample_o
);

   localparam int BAUD_W = PRE_W + SEL_W;
   localparam int CFG_W  = BAUD_W + 2;

   if (PRE_W < 1 || PRE_W > 8) begin : g_bad_pre
      $error("spi_bclk_gen: PRE_W out of range");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("spi_bclk_gen: SEL_W out of range");
   end

   // captured configuration: {prescale, power, cpol, cpha}
   logic [CFG_W-1:0] cfg_q;
   logic [PRE_W-1:0] pre_q;
   logic [SEL_W-1:0] sel_q;
   logic             cpol_q;
   logic             cpha_q;

   assign {pre_q, sel_q, cpol_q, cpha_q} = cfg_q;

   logic act_q;
   logic lvl_active;
   logic pre_term;
   logic pow_term;
   logic stop_now;
   logic tick;
   logic end_xfer;
   logic clr;

   assign stop_now = act_q & ~lvl_active & ~run_i;
   assign tick     = act_q & pre_term & pow_term & ~stop_now;
   assign end_xfer = tick & lvl_active & ~run_i;
   assign clr      = ~act_q | stop_now;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= '0;
         act_q <= 1'b0;
      end else if (clk_en_i) begin
         if (!act_q) begin
            cfg_q <= {baud_i, cpol_i, cpha_i};
            act_q <= run_i;
         end else if (stop_now || end_xfer) begin
            act_q <= 1'b0;
         end
      end
   end

   spi_bclk_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ce_i    (clk_en_i),
      .clr_i   (clr),
      .inc_i   (act_q),
      .limit_i (pre_q),
      .term_o  (pre_term)
   );

   spi_bclk_pow2 #(.SEL_W(SEL_W)) u_pow (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_i   (clk_en_i),
      .clr_i  (clr),
      .inc_i  (act_q & pre_term),
      .sel_i  (sel_q),
      .term_o (pow_term)
   );

   spi_bclk_phase u_phase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ce_i     (clk_en_i),
      .tick_i   (tick),
      .cpol_i   (cpol_q),
      .cpha_i   (cpha_q),
      .active_o (lvl_active),
      .sclk_o   (sclk_o),
      .drive_o  (drive_o),
      .sample_o (sample_o)
   );

endmodule

// File: rtl/spi_bclk_chk.sv
module spi_bclk_chk #(
   parameter int CFG_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             clk_en_i,
   input logic             sclk_o,
   input logic             drive_o,
   input logic             sample_o,
   input logic             act_q,
   input logic [CFG_W-1:0] cfg_q
);

   // R1
   a_r1_reset_quiet: assert property (@(posedge clk_i)
      !rst_ni |=> (!drive_o && !sample_o));

   // R9
   a_r9_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(drive_o && sample_o));

   // R8
   a_r8_freeze_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_en_i |=> $stable(sclk_o));

   // R8
   a_r8_no_strobe_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_en_i |-> (!drive_o && !sample_o));

   // R6
   a_r6_strobe_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((drive_o || sample_o) && $past(clk_en_i)) |-> (sclk_o != $past(sclk_o)));

   // R7
   a_r7_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(act_q) |-> $stable(cfg_q));

endmodule

bind spi_bclk_gen spi_bclk_chk #(.CFG_W(PRE_W + SEL_W + 2)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .clk_en_i (clk_en_i),
   .sclk_o   (sclk_o),
   .drive_o  (drive_o),
   .sample_o (sample_o),
   .act_q    (act_q),
   .cfg_q    (cfg_q)
);

// File: tb/spi_bclk_gen_tb.sv
module spi_bclk_gen_tb;

   logic       clk = 1'b0;
   logic       rst_ni;
   logic       clk_en_i;
   logic       run_i;
   logic       cpol_i;
   logic       cpha_i;
   logic [5:0] baud_i;
   logic       sclk_o;
   logic       drive_o;
   logic       sample_o;

   int checks = 0;
   int errors = 0;
   int cyc_cnt = 0;
   bit chk_on = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   spi_bclk_gen u_dut (
      .clk_i    (clk),
      .rst_ni   (rst_ni),
      .clk_en_i (clk_en_i),
      .run_i    (run_i),
      .cpol_i   (cpol_i),
      .cpha_i   (cpha_i),
      .baud_i   (baud_i),
      .sclk_o   (sclk_o),
      .drive_o  (drive_o),
      .sample_o (sample_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic int half_of(input int pre, input int sel);
      return (pre + 1) << sel;
   endfunction

   // ---------------- reference model: one flat counter per half-period
   bit m_act, m_lvl, m_cpol, m_cpha, m_drv, m_smp;
   int m_pre, m_sel, m_cnt;

   always @(posedge clk) begin
      if (!rst_ni) begin
         m_act <= 0; m_lvl <= 0; m_cpol <= 0; m_cpha <= 0;
         m_drv <= 0; m_smp <= 0; m_pre <= 0; m_sel <= 0; m_cnt <= 0;
      end else if (clk_en_i) begin
         m_drv <= 0;
         m_smp <= 0;
         if (!m_act) begin
            m_pre  <= int'(baud_i[5:3]);
            m_sel  <= int'(baud_i[2:0]);
            m_cpol <= cpol_i;
            m_cpha <= cpha_i;
            m_cnt  <= 0;
            m_act  <= run_i;
         end else if (!m_lvl && !run_i) begin
            m_act <= 0;
            m_cnt <= 0;
         end else if (m_cnt == half_of(m_pre, m_sel) - 1) begin
            m_cnt <= 0;
            m_lvl <= ~m_lvl;
            // leading edge (idle->active) samples for phase 0
            m_smp <= (!m_lvl) ^ m_cpha;
            m_drv <= !((!m_lvl) ^ m_cpha);
            if (m_lvl && !run_i) m_act <= 0;
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on && !done) begin
         string t_clk;
         string t_stb;
         if (!clk_en_i)                                          t_clk = "R8 frozen sclk";
         else if (m_act && !run_i)                               t_clk = "R5 stop sclk";
         else if (m_act && (int'(baud_i[5:3]) != m_pre ||
                            int'(baud_i[2:0]) != m_sel ||
                            cpol_i != m_cpol))                   t_clk = "R7 held config sclk";
         else if (m_act)                                         t_clk = "R3 running sclk";
         else                                                    t_clk = "R2 idle sclk";
         t_stb = clk_en_i ? "R6 strobe" : "R8 gated strobe";
         chk(t_clk, sclk_o, m_lvl ^ m_cpol);
         chk({t_stb, " drive"}, drive_o, m_drv & clk_en_i);
         chk({t_stb, " sample"}, sample_o, m_smp & clk_en_i);
         chk("R9 exclusive strobes", drive_o & sample_o, 0);
      end
   end

   // ---------------- watchdog
   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 190000 && !done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got %0d expected below 190000 cycles", cyc_cnt);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic cyc(input int n, input int pct);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         clk_en_i = (($urandom % 100) >= pct);
      end
   endtask

   initial begin
      int n;
      int h;
      int len;
      logic p;
      void'($urandom(32'd4711));
      rst_ni = 0; clk_en_i = 1; run_i = 0; cpol_i = 0; cpha_i = 0; baud_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset sclk", sclk_o, 0);
      chk("R1 reset drive", drive_o, 0);
      chk("R1 reset sample", sample_o, 0);
      @(posedge clk); #1;
      rst_ni = 1;
      chk_on = 1;
      @(negedge clk);
      chk("R1 after reset sclk", sclk_o, 0);

      // default divide-by-two run
      @(posedge clk); #1;
      run_i = 1;
      cyc(12, 0);
      run_i = 0;
      cyc(6, 0);

      // R2: idle level follows cpol
      cpol_i = 1;
      cyc(2, 0);
      @(negedge clk);
      chk("R2 idle level high", sclk_o, 1);
      cpol_i = 0;
      cyc(2, 0);

      // R4: first edge H cycles after start (P=2,S=1 -> H=6)
      baud_i = {3'd2, 3'd1};
      cyc(2, 0);
      run_i = 1;
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end while (sclk_o == 1'b0 && n < 200);
      chk("R4 first edge delay", n, half_of(2, 1) + 1);
      cyc(30, 0);
      run_i = 0;
      cyc(20, 0);

      // R7: change during transfer keeps old half-period (H=2)
      baud_i = {3'd0, 3'd1};
      cpha_i = 1;
      cyc(2, 0);
      run_i = 1;
      cyc(5, 0);
      baud_i = {3'd3, 3'd2};
      cpol_i = 1;
      @(negedge clk);
      p = sclk_o;
      do @(negedge clk); while (sclk_o == p);
      p = sclk_o;
      n = 0;
      do begin @(negedge clk); n++; end while (sclk_o == p && n < 100);
      chk("R7 half-period unchanged mid-transfer", n, 2);
      @(posedge clk); #1;
      run_i = 0;
      cyc(40, 0);
      cpol_i = 0;
      cpha_i = 0;

      // R5: one-cycle run pulse, stop at idle level
      baud_i = {3'd1, 3'd0};
      cyc(2, 0);
      run_i = 1;
      cyc(1, 0);
      run_i = 0;
      cyc(8, 0);

      // largest divisor
      baud_i = 6'h3F;
      cyc(2, 0);
      run_i = 1;
      cyc(2 * 2048 + 17, 0);
      run_i = 0;
      cyc(1100, 0);

      // constrained random segments
      for (int s = 0; s < 60; s++) begin
         int pct;
         pct    = ($urandom % 2) ? 15 : 0;
         baud_i = {3'($urandom % 8), 3'($urandom % 5)};
         cpol_i = 1'($urandom % 2);
         cpha_i = 1'($urandom % 2);
         h      = half_of(int'(baud_i[5:3]), int'(baud_i[2:0]));
         cyc(2 + $urandom % 3, pct);
         run_i = 1;
         len = 2 * h * (1 + $urandom % 3) + $urandom % (h + 1);
         cyc(len / 2, pct);
         if ($urandom % 2) begin
            baud_i = 6'($urandom);
            cpol_i = 1'($urandom % 2);
            cpha_i = 1'($urandom % 2);
         end
         cyc(len - len / 2, pct);
         run_i = 0;
         cyc(2 * h + 6, pct);
      end

      clk_en_i = 1;
      cyc(4, 0);
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule